// File: doc/BRIEF.md
# Serial Flash Write-Protection Gate

This block decides, for each command that a serial NOR flash slave has decoded, whether the command may run. The SPI front end shows the decoded command code, the target address, up to two data bytes and the serial-clock pulse count. It raises `cs_rise_i` for one cycle when chip select goes high. On that cycle the block checks the write-enable latch, the count alignment, the address against the protected region, and the pin/register hardware lock. One cycle later it returns a single-cycle `exec_o` or `abort_o` pulse.

The block holds the write-enable latch, the status protection fields and the configuration protection fields. A write-register command that is accepted updates those fields. Other accepted modifying commands only clear the latch, because the array itself lies outside this block.

The command codes on `cmd_i` are: 0 no-op, 1 write enable, 2 write disable, 3 page program, 4 sector erase, 5 bulk erase, 6 4 KB parameter erase, 7 8 KB parameter erase, 8 quad page program, 9 one-time-programmable byte program, 10 write registers. Codes 11 to 15 behave as no-op.

Top module: `wp_gate`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `wel_o`, `status_o`, `config_o`, `exec_o` and `abort_o` are all 0.
- R2: Command 1 sets the latch, and command 2 clears it. Each gives an `exec_o` pulse on the cycle after `cs_rise_i`, whatever the clock count.
- R3: A modifying command (codes 3 to 10) that arrives while the latch is 0 gives `abort_o`. No register changes.
- R4: A modifying command that passes every check gives `exec_o` and clears the latch on the same edge.
- R5: A modifying command whose clock count is not a multiple of eight (low three bits nonzero) gives `abort_o`. The latch keeps its value.
- R6: The block-protect field BP (status bits 4:2) protects 0 bytes at value 0 and the whole array at value 7. For a value k from 1 to 6 it protects 2^(k-1) sectors of 2^SECT_W bytes. The region sits at the top of the address space when config bit 5 is 0, and at the bottom when it is 1. Codes 3, 4, 6, 7 and 8 aimed into the region abort. Code 9 is not checked against the region.
- R7: Bulk erase (code 5) aborts whenever BP is nonzero.
- R8: Write registers (code 10) aborts when `wp_n_i` is 0 and status bit 7 is 1 at the same time. Either condition alone does not block it.
- R9: Write registers needs a count of at least 16, otherwise it aborts. At 16 it loads status bit 7 and the BP field from `data_i` bits 7 and 4:2. At 24 or more it also loads config bits 5, 4, 3 and 1 from `data_i` bits 13, 12, 11 and 9.
- R10: While config bit 4 (the BP lock) is 1, write registers leaves BP unchanged. A write register command cannot clear the lock; only reset can.
- R11: `exec_o` and `abort_o` are never high together. Each pulse lasts one cycle. A no-op code gives neither pulse.
- R12: The layout of `status_o` is bit 7 hardware-lock enable, bits 4:2 BP, bit 1 latch, other bits 0. The layout of `config_o` is bit 5 bottom placement, bit 4 BP lock, bit 3 BP volatility, bit 1 quad mode, other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_rise_i | input | 1 | One-cycle strobe at chip-select rise; command fields valid |
| cmd_i | input | 4 | Decoded command code |
| addr_i | input | ADDR_W | Target byte address |
| data_i | input | 16 | Register data: status in bits 7:0, config in bits 15:8 |
| sck_cnt_i | input | CNT_W | Serial clock pulses counted while selected |
| wp_n_i | input | 1 | Write-protect pin, active low |
| exec_o | output | 1 | Command accepted pulse |
| abort_o | output | 1 | Command rejected pulse |
| wel_o | output | 1 | Write-enable latch |
| status_o | output | 8 | Status protection fields |
| config_o | output | 8 | Configuration protection fields |

## Verification
The bench builds the block with ADDR_W=12, SECT_W=6 and CNT_W=8. This gives 64 sectors of 64 bytes, the same sector count as the default, so every BP step from one sector up to the whole array falls inside a 4 KB address space. The region edges on both sides can therefore be reached with short addresses. The 8-bit count also lets the 8, 16 and 24 write-register lengths and a misaligned count be driven directly.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_WREN = 4'd1,
    OP_WRDI = 4'd2,
    OP_PROG = 4'd3,
    OP_SERA = 4'd4,
    OP_BERA = 4'd5,
    OP_E4K  = 4'd6,
    OP_E8K  = 4'd7,
    OP_QPRG = 4'd8,
    OP_OTPB = 4'd9,
    OP_WREG = 4'd10
  } op_e;

  function automatic logic is_modify(input logic [3:0] code);
    return (code >= 4'd3) && (code <= 4'd10);
  endfunction

  function automatic logic is_array_op(input logic [3:0] code);
    case (code)
      OP_PROG, OP_SERA, OP_E4K, OP_E8K, OP_QPRG: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/wpg_region.sv
module wpg_region #(
  parameter int ADDR_W = 22,
  parameter int SECT_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        bp,
  input  logic              bottom,
  output logic              hit
);
  localparam int NS_W = ADDR_W - SECT_W;
  localparam logic [NS_W:0] ALL = (NS_W+1)'(1) << NS_W;

  logic [NS_W:0] sect;
  logic [NS_W:0] span;
  logic          unused_low;

  assign sect       = {1'b0, addr[ADDR_W-1:SECT_W]};
  assign unused_low = ^addr[SECT_W-1:0];

  // number of protected sectors for a BP value
  function automatic logic [NS_W:0] span_of(input logic [2:0] v);
    logic [NS_W:0] t;
    if (v == 3'd0) return '0;
    if (v == 3'd7) return ALL;
    t = (NS_W+1)'(1) << (v - 3'd1);
    if (t == '0 || t > ALL) return ALL;
    return t;
  endfunction

  assign span = span_of(bp);
  assign hit  = bottom ? (sect < span) : (sect >= (ALL - span));
endmodule

// File: rtl/wpg_wel.sv
module wpg_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wel <= 1'b0;
    else if (clr_i) wel <= 1'b0;
    else if (set_i) wel <= 1'b1;
  end
endmodule

// File: rtl/wpg_regs.sv
module wpg_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stat_i,
  input  logic        wr_cfg_i,
  input  logic [15:0] data_i,
  output logic        srwd,
  output logic [2:0]  bp,
  output logic        bottom,
  output logic        lock,
  output logic        bpvol,
  output logic        quad
);
  logic unused_bits;
  assign unused_bits = ^{data_i[15:14], data_i[10], data_i[8], data_i[6:5], data_i[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srwd <= 1'b0;
      bp   <= 3'd0;
    end else if (wr_stat_i) begin
      srwd <= data_i[7];
      if (!lock) bp <= data_i[4:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bottom <= 1'b0;
      lock   <= 1'b0;
      bpvol  <= 1'b0;
      quad   <= 1'b0;
    end else if (wr_cfg_i) begin
      bottom <= data_i[13];
      lock   <= lock | data_i[12];
      bpvol  <= data_i[11];
      quad   <= data_i[9];
    end
  end
endmodule

// File: rtl/wp_gate.sv
module wp_gate #(
  parameter int ADDR_W = 22,
  parameter int SECT_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_rise_i,
  input  logic [3:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  input  logic [CNT_W-1:0]  sck_cnt_i,
  input  logic              wp_n_i,
  output logic              exec_o,
  output logic              abort_o,
  output logic              wel_o,
  output logic [7:0]        status_o,
  output logic [7:0]        config_o
);
  import wpg_pkg::*;

  localparam logic [CNT_W-1:0] REG1_LEN = CNT_W'(16);
  localparam logic [CNT_W-1:0] REG2_LEN = CNT_W'(24);

  logic       wel_w, srwd_w, bottom_w, lock_w, bpvol_w, quad_w;
  logic [2:0] bp_w;
  logic       hit_w;

  // named decision events
  logic modify_w, count_ok_w, hw_lock_w, reject_w;
  logic accept_mod_w, ev_exec_w, ev_abort_w;
  logic wel_set_w, wel_clr_w, wr_stat_w, wr_cfg_w;

  wpg_region #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_region (
    .addr(addr_i), .bp(bp_w), .bottom(bottom_w), .hit(hit_w)
  );

  assign modify_w   = is_modify(cmd_i);
  assign count_ok_w = (sck_cnt_i[2:0] == 3'd0);
  assign hw_lock_w  = !wp_n_i && srwd_w;

  always_comb begin
    reject_w = 1'b0;
    if (modify_w) begin
      if (!wel_w || !count_ok_w)                  reject_w = 1'b1;
      if (is_array_op(cmd_i) && hit_w)            reject_w = 1'b1;
      if (cmd_i == OP_BERA && bp_w != 3'd0)       reject_w = 1'b1;
      if (cmd_i == OP_WREG && (hw_lock_w || sck_cnt_i < REG1_LEN))
                                                  reject_w = 1'b1;
    end
  end

  assign accept_mod_w = cs_rise_i && modify_w && !reject_w;
  assign ev_abort_w   = cs_rise_i && reject_w;
  assign wel_set_w    = cs_rise_i && (cmd_i == OP_WREN);
  assign wel_clr_w    = (cs_rise_i && (cmd_i == OP_WRDI)) || accept_mod_w;
  assign ev_exec_w    = wel_set_w || wel_clr_w;
  assign wr_stat_w    = accept_mod_w && (cmd_i == OP_WREG);
  assign wr_cfg_w     = wr_stat_w && (sck_cnt_i >= REG2_LEN);

  wpg_wel u_wel (
    .clk(clk), .rst_n(rst_n), .set_i(wel_set_w), .clr_i(wel_clr_w), .wel(wel_w)
  );

  wpg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stat_i(wr_stat_w), .wr_cfg_i(wr_cfg_w),
    .data_i(data_i), .srwd(srwd_w), .bp(bp_w), .bottom(bottom_w),
    .lock(lock_w), .bpvol(bpvol_w), .quad(quad_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_o  <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      exec_o  <= ev_exec_w;
      abort_o <= ev_abort_w;
    end
  end

  assign wel_o    = wel_w;
  assign status_o = {srwd_w, 2'b00, bp_w, wel_w, 1'b0};
  assign config_o = {2'b00, bottom_w, lock_w, bpvol_w, 1'b0, quad_w, 1'b0};
endmodule

// File: rtl/wp_gate_chk.sv
module wp_gate_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_rise_i,
  input logic [3:0]       cmd_i,
  input logic [CNT_W-1:0] sck_cnt_i,
  input logic             wp_n_i,
  input logic             exec_o,
  input logic             abort_o,
  input logic             wel_o,
  input logic [7:0]       status_o,
  input logic [7:0]       config_o,
  input logic             hit_w
);
  import wpg_pkg::*;

  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_o && abort_o));

  assert_pulse_short_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_o || abort_o) |-> $past(cs_rise_i));

  assert_wel_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_o) |-> $past(cs_rise_i && cmd_i == OP_WREN));

  assert_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_rise_i && is_modify(cmd_i) && !wel_o) |-> abort_o);

  assert_clear_after_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_o && $past(is_modify(cmd_i))) |-> !wel_o);

  assert_abort_keeps_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $stable(wel_o));

  assert_count_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_rise_i && is_modify(cmd_i) && sck_cnt_i[2:0] != 3'd0) |-> abort_o);

  assert_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_rise_i && is_array_op(cmd_i) && hit_w) |-> abort_o);

  assert_bulk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_rise_i && cmd_i == OP_BERA && status_o[4:2] != 3'd0) |-> abort_o);

  assert_hw_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_rise_i && cmd_i == OP_WREG && !wp_n_i && status_o[7]) |-> abort_o);

  assert_bp_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(config_o[4]) |-> ($stable(status_o[4:2]) && config_o[4]));
endmodule

bind wp_gate wp_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise_i(cs_rise_i), .cmd_i(cmd_i),
  .sck_cnt_i(sck_cnt_i), .wp_n_i(wp_n_i), .exec_o(exec_o), .abort_o(abort_o),
  .wel_o(wel_o), .status_o(status_o), .config_o(config_o), .hit_w(hit_w)
);

// File: tb/wp_gate_test.sv
module wp_gate_test;
  localparam int AW = 12;
  localparam int SW = 6;
  localparam int CW = 8;
  localparam int SPACE = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_rise_i = 1'b0;
  logic [3:0]    cmd_i = 4'd0;
  logic [AW-1:0] addr_i = '0;
  logic [15:0]   data_i = '0;
  logic [CW-1:0] sck_cnt_i = '0;
  logic          wp_n_i = 1'b1;
  logic          exec_o, abort_o, wel_o;
  logic [7:0]    status_o, config_o;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic       ex;
    logic       ab;
    logic       wel;
    logic [7:0] st;
    logic [7:0] cf;
    string      tag;
  } item_t;
  item_t sb_q[$];

  // bench-side model of the register state
  logic       m_wel = 0, m_srwd = 0, m_bot = 0, m_lock = 0, m_vol = 0, m_quad = 0;
  logic [2:0] m_bp = 0;

  always #5 clk = ~clk;

  wp_gate #(.ADDR_W(AW), .SECT_W(SW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_rise_i(cs_rise_i), .cmd_i(cmd_i),
    .addr_i(addr_i), .data_i(data_i), .sck_cnt_i(sck_cnt_i), .wp_n_i(wp_n_i),
    .exec_o(exec_o), .abort_o(abort_o), .wel_o(wel_o),
    .status_o(status_o), .config_o(config_o)
  );

  function automatic logic [7:0] m_status();
    return (m_srwd ? 8'h80 : 8'h00) | (8'(m_bp) * 8'd4) | (m_wel ? 8'h02 : 8'h00);
  endfunction

  function automatic logic [7:0] m_config();
    return (m_bot ? 8'h20 : 8'h00) | (m_lock ? 8'h10 : 8'h00) |
           (m_vol ? 8'h08 : 8'h00) | (m_quad ? 8'h02 : 8'h00);
  endfunction

  // protected byte range from the BP rule, counted in bytes
  function automatic logic in_region(input int a);
    int bytes;
    if (m_bp == 0) bytes = 0;
    else if (m_bp == 7) bytes = SPACE;
    else bytes = (1 << SW) * (1 << (m_bp - 1));
    if (m_bot) return a < bytes;
    return a >= SPACE - bytes;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input int cmd, input int addr, input logic [15:0] dat,
                       input int cnt, input string tag);
    item_t it;
    logic mod, rej;
    mod = (cmd >= 3 && cmd <= 10);
    rej = 0;
    if (mod) begin
      if (!m_wel) rej = 1;
      if (cnt % 8 != 0) rej = 1;
      if ((cmd == 3 || cmd == 4 || cmd == 6 || cmd == 7 || cmd == 8) && in_region(addr)) rej = 1;
      if (cmd == 5 && m_bp != 0) rej = 1;
      if (cmd == 10 && ((!wp_n_i && m_srwd) || cnt < 16)) rej = 1;
    end
    it.ex = (cmd == 1) || (cmd == 2) || (mod && !rej);
    it.ab = mod && rej;
    if (mod && !rej && cmd == 10) begin
      m_srwd = dat[7];
      if (!m_lock) m_bp = dat[4:2];
      if (cnt >= 24) begin
        m_bot = dat[13]; m_vol = dat[11]; m_quad = dat[9];
        m_lock = m_lock || dat[12];
      end
    end
    if (cmd == 1) m_wel = 1;
    if (cmd == 2 || (mod && !rej)) m_wel = 0;
    it.wel = m_wel;
    it.st  = m_status();
    it.cf  = m_config();
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    cs_rise_i = 1'b1; cmd_i = 4'(cmd); addr_i = AW'(addr);
    data_i = dat; sck_cnt_i = CW'(cnt);
    @(negedge clk);
    cs_rise_i = 1'b0;
    @(negedge clk);
  endtask

  // monitor: a strobe seen at an edge is judged at the next falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (cs_rise_i && rst_n) begin
        @(negedge clk);
        if (sb_q.size() == 0) begin
          total++; bad++;
          $display("FAIL scoreboard empty actual=1 expected=0");
        end else begin
          item_t e;
          e = sb_q.pop_front();
          check({e.tag, " exec"},   32'(exec_o),   32'(e.ex));
          check({e.tag, " abort"},  32'(abort_o),  32'(e.ab));
          check({e.tag, " wel"},    32'(wel_o),    32'(e.wel));
          check({e.tag, " status"}, 32'(status_o), 32'(e.st));
          check({e.tag, " config"}, 32'(config_o), 32'(e.cf));
        end
        @(negedge clk);
        check({"R11 pulse ends"}, 32'({exec_o, abort_o}), 32'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset exec",   32'(exec_o),   32'd0);
    check("R1 reset abort",  32'(abort_o),  32'd0);
    check("R1 reset status", 32'(status_o), 32'd0);
    check("R1 reset config", 32'(config_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset wel", 32'(wel_o), 32'd0);

    issue(3, 'h100, 16'h0, 32, "R3 program without latch");
    issue(1, 0, 16'h0, 8,  "R2 write enable");
    issue(2, 0, 16'h0, 8,  "R2 write disable");
    issue(1, 0, 16'h0, 13, "R2 enable any count");
    issue(3, 'h100, 16'h0, 33, "R5 misaligned count");
    issue(3, 'h100, 16'h0, 32, "R4 program accepted");
    issue(1, 0, 16'h0, 8,  "R2 enable");
    issue(10, 0, 16'h008C, 16, "R9 R12 status load");
    issue(1, 0, 16'h0, 8,  "R2 enable");
    issue(4, 'hF00, 16'h0, 32, "R6 top region edge");
    issue(4, 'hEFF, 16'h0, 32, "R6 below top region");
    issue(1, 0, 16'h0, 8,  "R2 enable");
    issue(5, 0, 16'h0, 8,  "R7 bulk with BP set");
    wp_n_i = 1'b0;
    issue(10, 0, 16'h0000, 16, "R8 pin and bit lock");
    wp_n_i = 1'b1;
    issue(10, 0, 16'h200C, 24, "R8 R9 pin high config load");
    issue(1, 0, 16'h0, 8,  "R2 enable");
    issue(3, 'h0FF, 16'h0, 32, "R6 bottom region");
    issue(3, 'h100, 16'h0, 32, "R6 above bottom region");
    issue(1, 0, 16'h0, 8,  "R2 enable");
    issue(10, 0, 16'h0000, 8, "R9 register write too short");
    issue(10, 0, 16'h3A1C, 24, "R9 R12 full register load");
    issue(1, 0, 16'h0, 8,  "R2 enable");
    issue(9, 0, 16'h0, 40, "R6 otp not region checked");
    issue(1, 0, 16'h0, 8,  "R2 enable");
    issue(10, 0, 16'h0000, 24, "R10 lock holds BP and itself");
    issue(1, 0, 16'h0, 8,  "R2 enable");
    issue(8, 0, 16'h0, 32, "R6 quad program whole array");
    issue(7, 'hFC0, 16'h0, 32, "R6 8k erase whole array");
    issue(6, 'h040, 16'h0, 32, "R6 4k erase whole array");
    issue(0, 0, 16'h0, 8,  "R11 no-op");
    issue(12, 0, 16'h0, 8, "R11 unused code");
    wp_n_i = 1'b0;
    issue(10, 0, 16'h0080, 16, "R8 pin low bit clear");
    issue(1, 0, 16'h0, 8,  "R2 enable");
    issue(10, 0, 16'h0000, 16, "R8 pin low bit set");
    wp_n_i = 1'b1;

    repeat (4) @(negedge clk);
    check("R11 scoreboard drained", 32'(sb_q.size()), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule